// File: doc/BRIEF.md
# Serial Flash Command Engine

This block turns a handful of byte-wide register writes into one complete transaction on a four-wire serial flash link: a clock, an active-low chip select, a data output and a data input. Software first sets up the transaction. It writes a command byte, a 16-bit count of serial clocks and three address bytes, and it can fill an outgoing data buffer. It then writes a start code, and the engine runs the transaction on its own. While it runs, a busy flag can be polled.

The serial link uses a mode with the clock idle low. Output data changes while the clock is low, and input data is sampled as the clock rises. Each clock phase lasts one system clock cycle. On the wire the bytes appear in a fixed sequence: the command, then the three address bytes, then the outgoing buffer. Every byte goes out starting with its bit 0. The count alone sets how many of these bytes are actually sent. Software stores command and address bytes bit-reversed, so no reversal is done in hardware. Every complete byte seen on the input line is kept. The second byte is placed in a status capture register, and bytes from the fifth onward land in a readback buffer.

Top module: `flashcmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, and reads of the busy flag (0x01), the status capture (0x20) and readback slot 0 (0x38) all return 0x00.
- R2: The clock count is formed from the high byte written at 0x00 and the low byte written at 0x08. The command is written at 0x10. The address bytes are written at 0x18, 0x20 and 0x28, and they are sent in that order.
- R3: A write of 0xFF to 0x7F8 while idle with a nonzero count starts a transaction, and a read at 0x01 returns 0x01 from the next cycle on. A write of any other value to 0x7F8 starts nothing.
- R4: Chip select stays low for exactly as many rising serial clock edges as the programmed count. The serial clock stays low while chip select is high, and each phase lasts one system cycle.
- R5: The wire bytes are sent in this order: command, address byte from 0x18, from 0x20, from 0x28, then outgoing buffer bytes 0, 1, and so on. Each byte goes out bit 0 first, and the output holds steady across each rising serial clock edge. Wire bytes past the end of the outgoing buffer are sent as 0x00.
- R6: Outgoing buffer byte i (i below 128) is written at 0x30 + 8*i.
- R7: Input bits are assembled with the first received bit in bit 0. A completed wire byte k with k of 4 or more is stored in readback slot k-4 (below 247), which is read at 0x38 + 8*(k-4). A partial final byte leaves its slot unchanged.
- R8: The completed wire byte 1 of a transaction is read back at 0x20.
- R9: Busy reads 0x00 again exactly one cycle after chip select rises, and a start write issued during a transaction is ignored.
- R10: A start write with a clock count of zero leaves the engine idle and chip select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 11 | Register bus byte address |
| busWrEn | input | 1 | Register bus write strobe |
| busWrData | input | 8 | Register bus write data |
| busRdData | output | 8 | Register bus read data (combinational on busAddr) |
| spiClk | output | 1 | Serial clock, idle low |
| spiCsN | output | 1 | Active-low chip select |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
A bit counter or byte index that is off by one shows up at once on the serial output: the scoreboard sees a shifted or misordered byte at the first byte boundary. A wrong remaining-clock counter shows up as a wrong edge count when chip select rises. A sampling slip or a misrouted capture is found only when software reads the status register or the readback slots after the transaction. A start decode that is too loose or a busy flag that stays set too long appears within one or two cycles on the busy read and on the chip select line.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;

  localparam int CNT_W = 16;

  typedef struct packed {
    logic load;
    logic sample;
    logic advance;
  } stepStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_TAIL
  } phase_t;

endpackage

// File: rtl/flashcmd_control.sv
module flashcmd_control
  import flashcmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             trigger,
  input  logic [CNT_W-1:0] clkCount,
  output stepStrobe_t      strobe,
  output logic             spiClk,
  output logic             spiCsN,
  output logic             busy
);

  phase_t           phase;
  logic [CNT_W-1:0] remain;
  logic             startOk;

  assign startOk = (phase == PH_IDLE) && trigger && (clkCount != '0);
  assign busy    = (phase != PH_IDLE);

  always_comb begin
    strobe.load    = startOk;
    strobe.sample  = (phase == PH_LOW);
    strobe.advance = (phase == PH_HIGH) && (remain != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      remain <= '0;
      spiClk <= 1'b0;
      spiCsN <= 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startOk) begin
            phase  <= PH_LOW;
            remain <= clkCount;
            spiCsN <= 1'b0;
          end
        end
        PH_LOW: begin
          spiClk <= 1'b1;
          remain <= remain - 1'b1;
          phase  <= PH_HIGH;
        end
        PH_HIGH: begin
          spiClk <= 1'b0;
          if (remain == '0) begin
            spiCsN <= 1'b1;
            phase  <= PH_TAIL;
          end else begin
            phase  <= PH_LOW;
          end
        end
        PH_TAIL: begin
          phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flashcmd_datapath.sv
module flashcmd_datapath
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 247
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  stepStrobe_t       strobe,
  input  logic              busy,
  input  logic              spiMiso,
  output logic              spiMosi,
  output logic              trigger,
  output logic [CNT_W-1:0]  clkCount
);

  localparam int TXI_W = $clog2(TX_DEPTH);
  localparam int RXI_W = $clog2(RX_DEPTH);
  localparam int IDX_W = CNT_W - 3;

  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(32'h000);
  localparam logic [ADDR_W-1:0] A_BUSY   = ADDR_W'(32'h001);
  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(32'h008);
  localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(32'h010);
  localparam logic [ADDR_W-1:0] A_ADR_HI = ADDR_W'(32'h018);
  localparam logic [ADDR_W-1:0] A_ADR_MD = ADDR_W'(32'h020);
  localparam logic [ADDR_W-1:0] A_ADR_LO = ADDR_W'(32'h028);
  localparam logic [ADDR_W-1:0] A_TX_BASE = ADDR_W'(32'h030);
  localparam logic [ADDR_W-1:0] A_RX_BASE = ADDR_W'(32'h038);
  localparam logic [ADDR_W-1:0] A_GO     = ADDR_W'(32'h7F8);
  localparam logic [ADDR_W-1:0] TX_LIM   = ADDR_W'(TX_DEPTH);
  localparam logic [ADDR_W-1:0] RX_LIM   = ADDR_W'(RX_DEPTH);

  logic [7:0] cntHi, cntLo, cmdReg, adrHi, adrMd, adrLo, statusReg;
  logic [7:0] txMem [TX_DEPTH];
  logic [7:0] rxMem [RX_DEPTH];
  logic [6:0] rxShift;
  logic [2:0] bitPos;
  logic [IDX_W-1:0] byteIdx;
  logic [IDX_W-1:0] dataIdx;
  logic [7:0] outByte;

  logic [ADDR_W-1:0] txOfs, txSlot, rxOfs, rxSlot;
  logic txWrHit, rxRdHit, rxStoreHit;

  assign clkCount = {cntHi, cntLo};
  assign trigger  = busWrEn && (busAddr == A_GO) && (busWrData == 8'hFF);

  assign txOfs   = busAddr - A_TX_BASE;
  assign txSlot  = txOfs >> 3;
  assign txWrHit = busWrEn && (busAddr >= A_TX_BASE) && (busAddr[2:0] == 3'd0) && (txSlot < TX_LIM);

  assign rxOfs   = busAddr - A_RX_BASE;
  assign rxSlot  = rxOfs >> 3;
  assign rxRdHit = (busAddr >= A_RX_BASE) && (busAddr[2:0] == 3'd0) && (rxSlot < RX_LIM);

  assign dataIdx    = byteIdx - IDX_W'(4);
  assign rxStoreHit = (byteIdx >= IDX_W'(4)) && (dataIdx < IDX_W'(RX_DEPTH));

  // configuration registers and outgoing buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      cntHi  <= '0;
      cntLo  <= '0;
      cmdReg <= '0;
      adrHi  <= '0;
      adrMd  <= '0;
      adrLo  <= '0;
      for (int i = 0; i < TX_DEPTH; i++) txMem[i] <= '0;
    end else if (busWrEn) begin
      if (busAddr == A_CNT_HI) cntHi  <= busWrData;
      if (busAddr == A_CNT_LO) cntLo  <= busWrData;
      if (busAddr == A_CMD)    cmdReg <= busWrData;
      if (busAddr == A_ADR_HI) adrHi  <= busWrData;
      if (busAddr == A_ADR_MD) adrMd  <= busWrData;
      if (busAddr == A_ADR_LO) adrLo  <= busWrData;
      if (txWrHit) txMem[txSlot[TXI_W-1:0]] <= busWrData;
    end
  end

  // serial position and input capture
  always_ff @(posedge clk) begin
    if (rst) begin
      bitPos    <= '0;
      byteIdx   <= '0;
      rxShift   <= '0;
      statusReg <= '0;
      for (int i = 0; i < RX_DEPTH; i++) rxMem[i] <= '0;
    end else if (strobe.load) begin
      bitPos  <= '0;
      byteIdx <= '0;
    end else begin
      if (strobe.sample) begin
        if (bitPos != 3'd7) begin
          rxShift[bitPos] <= spiMiso;
        end else begin
          if (byteIdx == IDX_W'(1)) statusReg <= {spiMiso, rxShift};
          if (rxStoreHit) rxMem[dataIdx[RXI_W-1:0]] <= {spiMiso, rxShift};
        end
      end
      if (strobe.advance) begin
        bitPos <= bitPos + 3'd1;
        if (bitPos == 3'd7) byteIdx <= byteIdx + IDX_W'(1);
      end
    end
  end

  // outgoing byte selection by wire position
  always_comb begin
    if (byteIdx == IDX_W'(0))      outByte = cmdReg;
    else if (byteIdx == IDX_W'(1)) outByte = adrHi;
    else if (byteIdx == IDX_W'(2)) outByte = adrMd;
    else if (byteIdx == IDX_W'(3)) outByte = adrLo;
    else if (dataIdx < IDX_W'(TX_DEPTH)) outByte = txMem[dataIdx[TXI_W-1:0]];
    else outByte = '0;
  end

  assign spiMosi = outByte[bitPos];

  // register read mux
  always_comb begin
    if (busAddr == A_BUSY)        busRdData = {7'd0, busy};
    else if (busAddr == A_ADR_MD) busRdData = statusReg;
    else if (rxRdHit)             busRdData = rxMem[rxSlot[RXI_W-1:0]];
    else                          busRdData = '0;
  end

endmodule

// File: rtl/flashcmd_engine.sv
module flashcmd_engine
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int TX_DEPTH = 128,
  parameter int RX_DEPTH = 247
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  output logic              spiClk,
  output logic              spiCsN,
  output logic              spiMosi,
  input  logic              spiMiso
);

  stepStrobe_t      strobe;
  logic             busy;
  logic             trigger;
  logic [CNT_W-1:0] clkCount;

  flashcmd_control u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .trigger  (trigger),
    .clkCount (clkCount),
    .strobe   (strobe),
    .spiClk   (spiClk),
    .spiCsN   (spiCsN),
    .busy     (busy)
  );

  flashcmd_datapath #(
    .ADDR_W   (ADDR_W),
    .TX_DEPTH (TX_DEPTH),
    .RX_DEPTH (RX_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .strobe    (strobe),
    .busy      (busy),
    .spiMiso   (spiMiso),
    .spiMosi   (spiMosi),
    .trigger   (trigger),
    .clkCount  (clkCount)
  );

endmodule

// File: rtl/flashcmd_engine_checker.sv
module flashcmd_engine_checker (
  input logic        clk,
  input logic        rst,
  input logic        spiClk,
  input logic        spiCsN,
  input logic        spiMosi,
  input logic        busy,
  input logic        trigger,
  input logic [15:0] clkCount
);

  p_start_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && trigger && clkCount != 16'd0) |=> busy);

  p_zero_count_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && trigger && clkCount == 16'd0) |=> (!busy && spiCsN));

  p_cs_inside_busy_r9: assert property (@(posedge clk) disable iff (rst)
    !spiCsN |-> busy);

  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(spiCsN) |=> !busy);

  p_busy_ignores_start_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !spiCsN && trigger) |=> busy);

  p_clk_idle_r4: assert property (@(posedge clk) disable iff (rst)
    spiCsN |-> !spiClk);

  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(spiClk) |-> $stable(spiMosi));

endmodule

bind flashcmd_engine flashcmd_engine_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .spiClk   (spiClk),
  .spiCsN   (spiCsN),
  .spiMosi  (spiMosi),
  .busy     (busy),
  .trigger  (trigger),
  .clkCount (clkCount)
);

// File: tb/flashcmd_engine_test.sv
module flashcmd_engine_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic        spiClk, spiCsN, spiMosi, spiMiso;

  int checks = 0, errors = 0;
  int monChecks = 0, monErrors = 0;
  int csFalls = 0;
  int seed = 0;
  int mBit = 0;
  logic [7:0] txModel [128];
  logic [7:0] expQ [$];
  int expCnt [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  flashcmd_engine uut (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .spiClk(spiClk),
    .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  function automatic logic [7:0] patt(input int s, input int k);
    return 8'((k * 29) + (s * 71) + 91);
  endfunction

  function automatic logic pattBit(input int s, input int b);
    logic [7:0] v;
    v = patt(s, b / 8);
    return v[b % 8];
  endfunction

  // flash responder: next bit presented after each rising clock
  always @(posedge spiClk or negedge spiCsN) begin
    if (spiClk) mBit = mBit + 1;
    else mBit = 0;
  end
  assign spiMiso = pattBit(seed, mBit);

  // scoreboard monitor
  logic prevCs = 1'b1;
  int monBits = 0;
  logic [7:0] monByte = '0;
  always @(posedge spiClk or negedge spiCsN or posedge spiCsN) begin
    if (spiCsN !== prevCs) begin
      if (spiCsN === 1'b0) begin
        monBits = 0;
        csFalls = csFalls + 1;
      end else begin
        monChecks = monChecks + 1;
        if (expCnt.size() == 0) begin
          monErrors = monErrors + 1;
          $display("FAIL R9 unexpected transaction: got %0d edges, expected none", monBits);
        end else begin
          int e;
          e = expCnt.pop_front();
          if (monBits != e) begin
            monErrors = monErrors + 1;
            $display("FAIL R2/R4 edge count: got %0d expected %0d", monBits, e);
          end
        end
      end
      prevCs = spiCsN;
    end else if (spiClk === 1'b1 && spiCsN === 1'b0) begin
      monByte[monBits % 8] = spiMosi;
      monBits = monBits + 1;
      if (monBits % 8 == 0) begin
        monChecks = monChecks + 1;
        if (expQ.size() == 0) begin
          monErrors = monErrors + 1;
          $display("FAIL R5 extra wire byte: got %h expected none", monByte);
        end else begin
          logic [7:0] e;
          e = expQ.pop_front();
          if (monByte !== e) begin
            monErrors = monErrors + 1;
            $display("FAIL R5/R2 wire byte %0d: got %h expected %h", monBits / 8 - 1, monByte, e);
          end
        end
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int a, input logic [7:0] d);
    busAddr = 11'(a);
    busWrData = d;
    busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input int a, output logic [7:0] d);
    busAddr = 11'(a);
    #1;
    d = busRdData;
  endtask

  task automatic loadTx(input int i, input logic [7:0] v);
    busWrite(8'h30 + 8 * i, v);
    txModel[i] = v;
  endtask

  task automatic setup(input int cnt, input logic [7:0] cmd, input logic [7:0] a2,
                       input logic [7:0] a1, input logic [7:0] a0);
    busWrite(8'h00, 8'(cnt >> 8));
    busWrite(8'h08, 8'(cnt));
    busWrite(8'h10, cmd);
    busWrite(8'h18, a2);
    busWrite(8'h20, a1);
    busWrite(8'h28, a0);
  endtask

  task automatic expectBytes(input int cnt, input logic [7:0] cmd, input logic [7:0] a2,
                             input logic [7:0] a1, input logic [7:0] a0);
    for (int k = 0; k < cnt / 8; k++) begin
      if (k == 0) expQ.push_back(cmd);
      else if (k == 1) expQ.push_back(a2);
      else if (k == 2) expQ.push_back(a1);
      else if (k == 3) expQ.push_back(a0);
      else if (k - 4 < 128) expQ.push_back(txModel[k - 4]);
      else expQ.push_back(8'h00);
    end
    expCnt.push_back(cnt);
  endtask

  task automatic finishTxn();
    logic [7:0] r;
    @(posedge spiCsN);
    @(negedge clk);
    busRead(8'h01, r);
    check("R9 busy held one cycle after release", r, 8'h01);
    @(negedge clk);
    busRead(8'h01, r);
    check("R9 busy cleared after release", r, 8'h00);
  endtask

  task automatic runTxn(input int cnt, input logic [7:0] cmd, input logic [7:0] a2,
                        input logic [7:0] a1, input logic [7:0] a0);
    logic [7:0] r;
    setup(cnt, cmd, a2, a1, a0);
    expectBytes(cnt, cmd, a2, a1, a0);
    seed = seed + 1;
    busWrite(12'h7F8, 8'hFF);
    busRead(8'h01, r);
    check("R3 busy after start", r, 8'h01);
    finishTxn();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired: got hung run expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks + monChecks + 1, errors + monErrors + 1);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int oldSeed;
    int falls;
    for (int i = 0; i < 128; i++) txModel[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    busRead(8'h01, r); check("R1 busy at reset", r, 8'h00);
    busRead(8'h20, r); check("R1 status at reset", r, 8'h00);
    busRead(8'h38, r); check("R1 slot0 at reset", r, 8'h00);
    check("R1 cs high", {7'd0, spiCsN}, 8'h01);
    check("R1 clk low", {7'd0, spiClk}, 8'h00);

    // single command byte
    runTxn(8, 8'h60, 8'h00, 8'h00, 8'h00);

    // R8 status read
    runTxn(16, 8'hA0, 8'h11, 8'h22, 8'h33);
    busRead(8'h20, r); check("R8 status capture", r, patt(seed, 1));

    // R7 identification read: fifth wire byte into slot 0
    runTxn(40, 8'hD5, 8'h00, 8'h00, 8'h00);
    busRead(8'h38, r); check("R7 id byte slot0", r, patt(seed, 4));

    // R6 program with six buffered bytes
    for (int i = 0; i < 6; i++) loadTx(i, 8'(8'hC1 + 13 * i));
    runTxn(32 + 8 * 6, 8'h40, 8'h80, 8'h40, 8'h20);

    // R7 read with twelve data bytes
    runTxn(32 + 8 * 12, 8'hC0, 8'h00, 8'h08, 8'h01);
    for (int i = 0; i < 12; i++) begin
      busRead(8'h38 + 8 * i, r);
      check("R7 read slot", r, patt(seed, 4 + i));
    end

    // R7 partial final byte leaves slot untouched
    oldSeed = seed;
    runTxn(44, 8'hC0, 8'h01, 8'h02, 8'h03);
    busRead(8'h38, r); check("R7 complete byte after partial run", r, patt(seed, 4));
    busRead(8'h40, r); check("R7 partial byte discarded", r, patt(oldSeed, 5));

    // R9 start during transaction ignored
    falls = csFalls;
    setup(40, 8'hD5, 8'h00, 8'h00, 8'h00);
    expectBytes(40, 8'hD5, 8'h00, 8'h00, 8'h00);
    seed = seed + 1;
    busWrite(12'h7F8, 8'hFF);
    repeat (10) @(negedge clk);
    busWrite(12'h7F8, 8'hFF);
    finishTxn();
    repeat (10) @(negedge clk);
    check("R9 one transaction for two starts", 8'(csFalls - falls), 8'd1);

    // R3 wrong start code
    falls = csFalls;
    busWrite(12'h7F8, 8'h12);
    busRead(8'h01, r); check("R3 non-start code busy", r, 8'h00);
    repeat (4) @(negedge clk);
    check("R3 non-start code no select", 8'(csFalls - falls), 8'd0);

    // R10 zero count
    setup(0, 8'h60, 8'h00, 8'h00, 8'h00);
    busWrite(12'h7F8, 8'hFF);
    busRead(8'h01, r); check("R10 zero count busy", r, 8'h00);
    repeat (4) @(negedge clk);
    check("R10 zero count no select", 8'(csFalls - falls), 8'd0);

    // R2/R5/R6 long program past buffer end, high count byte in use
    for (int i = 0; i < 128; i++) loadTx(i, 8'(i * 3 + 1));
    runTxn(8 * 134, 8'h40, 8'h00, 8'h10, 8'h00);
    busRead(8'h38 + 8 * 127, r); check("R7 slot 127", r, patt(seed, 131));
    busRead(8'h38 + 8 * 129, r); check("R7 slot 129", r, patt(seed, 133));

    repeat (5) @(negedge clk);
    check("R5 scoreboard drained", 8'(expQ.size() + expCnt.size()), 8'd0);
    $display("  CHECKS %0d ERRORS %0d", checks + monChecks, errors + monErrors);
    $finish;
  end

endmodule